// File: doc/BRIEF.md
# Dual-Channel Converter Output Code Formatter

This block models the digital back end of a two-channel pipelined analog-to-digital converter. Each channel delivers a signed 13-bit conversion result, two's complement, every sample clock. It also delivers an over-range and an under-range indication. The block delays each result to match the converter pipeline. It then converts the result to the selected output coding, applies the selected word configuration, computes a per-channel out-of-range flag and registers everything onto a parallel output bus.

The coding is either offset binary or two's complement. The word configuration is one of three:
- **Full:** all 13 bits.
- **Drop:** 12 bits, with the least significant bit discarded.
- **Wrap:** a reduced-range 12-bit two's-complement word that wraps instead of clamping. Its range status is carried in the top two bits.

Output tristate is modelled by registered drive-enable outputs, one per channel data bus and one for the data-sync clock. A power-down input forces all data and flag outputs to zero and flushes the pipeline.

Top module: `dual_adc_fmt`

## Requirements
- R1: A sample presented on `rawCode`, `rawOver` and `rawUnder` and captured at a rising edge appears, formatted, on `dataOut` and `rangeFlag` just after the 12th rising edge that follows (`LATENCY` = 12). The configuration inputs are sampled at that last edge.
- R2: With `modeSel` = 0 and `fmtTwos` = 0, the output is offset binary, equal to the signed raw value plus 4096. A raw value of zero gives 1 0000 0000 0000.
- R3: With `fmtTwos` = 1 in modes 0 and 1, the output equals the offset-binary word with bit 12 inverted.
- R4: In modes 0 and 1, `rawOver` forces the offset-binary word to all ones and `rawUnder` forces it to all zeros. If both are high, over-range wins. In two's complement these become 0 1111 1111 1111 and 1 0000 0000 0000.
- R5: In mode 0, `rangeFlag` is high exactly when the offset-binary form of the output word is all ones or all zeros.
- R6: In mode 1 (`modeSel` = 1), bits [12:1] carry the same value as in mode 0 and bit 0 is driven to 0. `rangeFlag` is high when the twelve upper bits of the offset-binary word are all equal and the discarded bit equals them too.
- R7: In mode 2 (`modeSel` = 2), the output is the raw two's-complement value unchanged across all 13 bits. The receiver uses bits [11:0], which wrap. `fmtTwos`, `rawOver` and `rawUnder` have no effect.
- R8: In mode 2, `rangeFlag` is high when bit 12 differs from bit 11. Bit 12 = 0 with bit 11 = 1 means over-range; bit 12 = 1 with bit 11 = 0 means under-range.
- R9: `dataDrive[c]` is high one clock after `oeN[c]` is sampled low, and low one clock after it is sampled high.
- R10: `syncDrive` is high one clock after `syncEnN` is sampled low, and low one clock after it is sampled high.
- R11: After reset, or one clock after `pwrDown` is sampled high, `dataOut` and `rangeFlag` are zero. The pipeline is cleared, so they stay zero until a sample captured after `pwrDown` falls reaches the output.
- R12: `modeSel` = 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrDown | input | 1 | Power-down: zero outputs and flush the pipeline |
| modeSel | input | 2 | Word configuration: 0 full, 1 drop LSB, 2 wrap, 3 same as 0 |
| fmtTwos | input | 1 | 0 offset binary, 1 two's complement (modes 0, 1, 3) |
| rawCode | input | 2x13 | Signed raw conversion result per channel |
| rawOver | input | 2 | Over-range indication per channel |
| rawUnder | input | 2 | Under-range indication per channel |
| oeN | input | 2 | Active-low data output enable per channel |
| syncEnN | input | 1 | Active-low enable of the data-sync clock output |
| dataOut | output | 2x13 | Formatted output word per channel |
| rangeFlag | output | 2 | Out-of-range flag per channel |
| dataDrive | output | 2 | Per-channel data bus drive enable (low means high impedance) |
| syncDrive | output | 1 | Data-sync clock drive enable |

## Verification
Every one of the 8192 raw codes is streamed through both channels in all four mode settings and both codings. Forced over- and under-range pulses are interleaved, including cycles where both are high, which separates saturation priority from the plain arithmetic mapping. Channel 1 receives a scrambled code order, which exposes any cross-channel or lane swap. The wrap sweep crosses the ±2048 boundaries and confirms that the range inputs are ignored there. A power-down pulse in the middle of a sweep shows the zero hold and the full pipeline flush, and toggling enables check the one-cycle drive timing.

// File: rtl/dual_adc_fmt_pkg.sv
package dual_adc_fmt_pkg;

  // Output word configuration selected by modeSel.
  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_DROP  = 2'd1,
    MODE_WRAP  = 2'd2,
    MODE_SPARE = 2'd3
  } outModeT;

  // Strobes passed from the control unit to the datapath.
  typedef struct packed {
    logic clearLine;  // flush the latency line
    logic holdZero;   // force the output register to zero
    logic wrapMode;   // pass the raw code through, wrap-style flag
    logic dropLsb;    // clear bit 0 of the output word
    logic twosOut;    // flip the MSB of the offset-binary word
  } fmtStrobeT;

endpackage

// File: rtl/dual_adc_fmt_ctrl.sv
module dual_adc_fmt_ctrl
  import dual_adc_fmt_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwrDown,
  input  logic [1:0]     modeSel,
  input  logic           fmtTwos,
  input  logic [NCH-1:0] oeN,
  input  logic           syncEnN,
  output fmtStrobeT      strobe,
  output logic [NCH-1:0] dataDrive,
  output logic           syncDrive
);

  outModeT modeDec;

  always_comb begin
    modeDec          = outModeT'(modeSel);
    strobe.clearLine = pwrDown;
    strobe.holdZero  = pwrDown;
    strobe.wrapMode  = (modeDec == MODE_WRAP);
    strobe.dropLsb   = (modeDec == MODE_DROP);
    // The wrap word is always two's complement, so the coding select is masked.
    strobe.twosOut   = fmtTwos && (modeDec != MODE_WRAP);
  end

  // Drive enables are registered to line up with the output data register.
  for (genvar c = 0; c < NCH; c++) begin : g_drive
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dataDrive[c] <= 1'b0;
      else        dataDrive[c] <= !oeN[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncDrive <= 1'b0;
    else        syncDrive <= !syncEnN;
  end

endmodule

// File: rtl/dual_adc_fmt_dp.sv
module dual_adc_fmt_dp
  import dual_adc_fmt_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int CW      = 13,
  parameter int LATENCY = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  fmtStrobeT                strobe,
  input  logic [NCH-1:0][CW-1:0]   rawCode,
  input  logic [NCH-1:0]           rawOver,
  input  logic [NCH-1:0]           rawUnder,
  output logic [NCH-1:0][CW-1:0]   dataOut,
  output logic [NCH-1:0]           rangeFlag
);

  // LATENCY line stages plus the output register give LATENCY edges
  // between the capture edge and the edge that updates dataOut.
  localparam int              LINE_DEPTH = LATENCY;
  localparam logic [CW-1:0]   MSB_MASK   = {1'b1, {(CW-1){1'b0}}};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CW-1:0] lineCode  [LINE_DEPTH];
    logic          lineLive  [LINE_DEPTH];
    logic          lineOver  [LINE_DEPTH];
    logic          lineUnder [LINE_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LINE_DEPTH; i++) begin
          lineCode[i]  <= '0;
          lineLive[i]  <= 1'b0;
          lineOver[i]  <= 1'b0;
          lineUnder[i] <= 1'b0;
        end
      end else if (strobe.clearLine) begin
        for (int i = 0; i < LINE_DEPTH; i++) begin
          lineCode[i]  <= '0;
          lineLive[i]  <= 1'b0;
          lineOver[i]  <= 1'b0;
          lineUnder[i] <= 1'b0;
        end
      end else begin
        lineCode[0]  <= rawCode[c];
        lineLive[0]  <= 1'b1;
        lineOver[0]  <= rawOver[c];
        lineUnder[0] <= rawUnder[c];
        for (int i = 1; i < LINE_DEPTH; i++) begin
          lineCode[i]  <= lineCode[i-1];
          lineLive[i]  <= lineLive[i-1];
          lineOver[i]  <= lineOver[i-1];
          lineUnder[i] <= lineUnder[i-1];
        end
      end
    end

    logic [CW-1:0] tapCode;
    logic          tapLive, tapOver, tapUnder;
    logic [CW-1:0] offWord, satWord, outWord;
    logic          outFlag;

    assign tapCode  = lineCode[LINE_DEPTH-1];
    assign tapLive  = lineLive[LINE_DEPTH-1];
    assign tapOver  = lineOver[LINE_DEPTH-1];
    assign tapUnder = lineUnder[LINE_DEPTH-1];

    always_comb begin
      // Centre the signed code: flipping the MSB adds half scale.
      offWord = tapCode ^ MSB_MASK;
      if (tapOver)       satWord = '1;
      else if (tapUnder) satWord = '0;
      else               satWord = offWord;

      if (strobe.wrapMode) begin
        outWord = tapCode;
        outFlag = tapCode[CW-1] ^ tapCode[CW-2];
      end else begin
        outWord = strobe.twosOut ? (satWord ^ MSB_MASK) : satWord;
        outFlag = (&satWord) || !(|satWord);
        if (strobe.dropLsb) outWord[0] = 1'b0;
      end
    end

    logic [CW-1:0] wordReg;
    logic          flagReg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wordReg <= '0;
        flagReg <= 1'b0;
      end else if (strobe.holdZero || !tapLive) begin
        wordReg <= '0;
        flagReg <= 1'b0;
      end else begin
        wordReg <= outWord;
        flagReg <= outFlag;
      end
    end

    assign dataOut[c]   = wordReg;
    assign rangeFlag[c] = flagReg;
  end

endmodule

// File: rtl/dual_adc_fmt.sv
module dual_adc_fmt
  import dual_adc_fmt_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int CW      = 13,
  parameter int LATENCY = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwrDown,
  input  logic [1:0]             modeSel,
  input  logic                   fmtTwos,
  input  logic [NCH-1:0][CW-1:0] rawCode,
  input  logic [NCH-1:0]         rawOver,
  input  logic [NCH-1:0]         rawUnder,
  input  logic [NCH-1:0]         oeN,
  input  logic                   syncEnN,
  output logic [NCH-1:0][CW-1:0] dataOut,
  output logic [NCH-1:0]         rangeFlag,
  output logic [NCH-1:0]         dataDrive,
  output logic                   syncDrive
);

  fmtStrobeT strobe;

  dual_adc_fmt_ctrl #(.NCH(NCH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrDown   (pwrDown),
    .modeSel   (modeSel),
    .fmtTwos   (fmtTwos),
    .oeN       (oeN),
    .syncEnN   (syncEnN),
    .strobe    (strobe),
    .dataDrive (dataDrive),
    .syncDrive (syncDrive)
  );

  dual_adc_fmt_dp #(.NCH(NCH), .CW(CW), .LATENCY(LATENCY)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rawCode   (rawCode),
    .rawOver   (rawOver),
    .rawUnder  (rawUnder),
    .dataOut   (dataOut),
    .rangeFlag (rangeFlag)
  );

endmodule

// File: rtl/dual_adc_fmt_chk.sv
module dual_adc_fmt_chk #(
  parameter int NCH     = 2,
  parameter int CW      = 13,
  parameter int LATENCY = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pwrDown,
  input logic [1:0]             modeSel,
  input logic                   fmtTwos,
  input logic [NCH-1:0]         oeN,
  input logic                   syncEnN,
  input logic [NCH-1:0][CW-1:0] dataOut,
  input logic [NCH-1:0]         rangeFlag,
  input logic [NCH-1:0]         dataDrive,
  input logic                   syncDrive
);

  localparam int CNTW = $clog2(LATENCY + 2);

  // Cycles since the last flush, saturating just above the latency window.
  logic [CNTW-1:0] sinceClear;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sinceClear <= '0;
    else if (pwrDown)                        sinceClear <= '0;
    else if (sinceClear <= CNTW'(LATENCY))   sinceClear <= sinceClear + 1'b1;
  end

  logic flushed;
  assign flushed = (sinceClear > CNTW'(LATENCY));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_pd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwrDown |=> (dataOut[c] == '0) && !rangeFlag[c]);

    p_flush_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sinceClear <= CNTW'(LATENCY)) |-> (dataOut[c] == '0) && !rangeFlag[c]);

    p_full_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flushed && !pwrDown && modeSel == 2'd0 && !fmtTwos)
        |=> rangeFlag[c] == ((&dataOut[c]) || !(|dataOut[c])));

    p_drop_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwrDown && modeSel == 2'd1) |=> !dataOut[c][0]);

    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwrDown && modeSel == 2'd2)
        |=> rangeFlag[c] == (dataOut[c][CW-1] ^ dataOut[c][CW-2]));

    p_drive_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !oeN[c] |=> dataDrive[c]);

    p_drive_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oeN[c] |=> !dataDrive[c]);
  end

  p_sync_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !syncEnN |=> syncDrive);

  p_sync_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    syncEnN |=> !syncDrive);

endmodule

bind dual_adc_fmt dual_adc_fmt_chk #(.NCH(NCH), .CW(CW), .LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwrDown   (pwrDown),
  .modeSel   (modeSel),
  .fmtTwos   (fmtTwos),
  .oeN       (oeN),
  .syncEnN   (syncEnN),
  .dataOut   (dataOut),
  .rangeFlag (rangeFlag),
  .dataDrive (dataDrive),
  .syncDrive (syncDrive)
);

// File: tb/dual_adc_fmt_test.sv
module dual_adc_fmt_test;

  localparam int NCH = 2;
  localparam int CW  = 13;
  localparam int LAT = 12;
  localparam int HN  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrDown = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic fmtTwos = 1'b0;
  logic [NCH-1:0][CW-1:0] rawCode = '0;
  logic [NCH-1:0] rawOver = '0;
  logic [NCH-1:0] rawUnder = '0;
  logic [NCH-1:0] oeN = '1;
  logic syncEnN = 1'b1;
  logic [NCH-1:0][CW-1:0] dataOut;
  logic [NCH-1:0] rangeFlag;
  logic [NCH-1:0] dataDrive;
  logic syncDrive;

  dual_adc_fmt #(.NCH(NCH), .CW(CW), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .pwrDown(pwrDown), .modeSel(modeSel),
    .fmtTwos(fmtTwos), .rawCode(rawCode), .rawOver(rawOver),
    .rawUnder(rawUnder), .oeN(oeN), .syncEnN(syncEnN),
    .dataOut(dataOut), .rangeFlag(rangeFlag), .dataDrive(dataDrive),
    .syncDrive(syncDrive)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [CW-1:0]  hCode [HN][NCH];
  logic           hOv   [HN][NCH];
  logic           hUn   [HN][NCH];
  logic [1:0]     hMode [HN];
  logic           hTw   [HN];
  logic [NCH-1:0] hOe   [HN];
  logic           hSyn  [HN];
  logic           hRst  [HN];
  logic           hDead [HN];

  // Expected word and flag from the requirements, computed arithmetically.
  function automatic void calcExp(input logic [CW-1:0] v, input logic ov,
                                  input logic un, input logic [1:0] md,
                                  input logic tw, output logic [CW-1:0] w,
                                  output logic f);
    int full;
    int half;
    int s;
    int ob;
    int o;
    full = 1 << CW;
    half = 1 << (CW - 1);
    s = int'(v);
    if (s >= half) s = s - full;
    if (md == 2'd2) begin
      w = v;                                         // R7 wrap word
      f = (s >= half / 2) || (s < -(half / 2));      // R8 12-bit range
    end else begin
      if (ov)      ob = full - 1;                    // R4 over wins
      else if (un) ob = 0;
      else         ob = s + half;                    // R2 offset binary
      f = (ob == full - 1) || (ob == 0);             // R5 / R6 flag
      o = tw ? (ob + half) % full : ob;              // R3 two's complement
      if (md == 2'd1) o = o - (o % 2);               // R6 LSB dropped
      w = o[CW-1:0];
    end
  endfunction

  task automatic checkOutputs();
    int m;
    int km;
    int kc;
    bit dead;
    string tag;
    logic [CW-1:0] ew;
    logic ef;
    kc = (cyc - 1) % HN;
    m = cyc - LAT - 1;
    if (m >= 0) begin
      km = m % HN;
      dead = 1'b0;
      for (int j = m; j < cyc; j++) if (hDead[j % HN]) dead = 1'b1;
      if (dead)                 tag = "R11";
      else if (hMode[kc] == 0)  tag = "R1/R2/R3/R4/R5";
      else if (hMode[kc] == 1)  tag = "R1/R6";
      else if (hMode[kc] == 2)  tag = "R1/R7/R8";
      else                      tag = "R1/R12";
      for (int c = 0; c < NCH; c++) begin
        if (dead) begin
          ew = '0;
          ef = 1'b0;
        end else begin
          calcExp(hCode[km][c], hOv[km][c], hUn[km][c], hMode[kc], hTw[kc], ew, ef);
        end
        checks++;
        if (dataOut[c] !== ew) begin
          errors++;
          $display("FAIL %s data ch%0d cycle %0d actual=%h expected=%h",
                   tag, c, cyc, dataOut[c], ew);
        end
        checks++;
        if (rangeFlag[c] !== ef) begin
          errors++;
          $display("FAIL %s flag ch%0d cycle %0d actual=%b expected=%b",
                   tag, c, cyc, rangeFlag[c], ef);
        end
      end
    end
    if (cyc >= 1 && hRst[kc]) begin
      checks++;
      if (dataDrive !== ~hOe[kc]) begin
        errors++;
        $display("FAIL R9 dataDrive cycle %0d actual=%b expected=%b",
                 cyc, dataDrive, ~hOe[kc]);
      end
      checks++;
      if (syncDrive !== !hSyn[kc]) begin
        errors++;
        $display("FAIL R10 syncDrive cycle %0d actual=%b expected=%b",
                 cyc, syncDrive, !hSyn[kc]);
      end
    end
  endtask

  // Record the inputs driven now, let one edge pass, then check at the falling edge.
  task automatic step();
    int k;
    k = cyc % HN;
    for (int c = 0; c < NCH; c++) begin
      hCode[k][c] = rawCode[c];
      hOv[k][c]   = rawOver[c];
      hUn[k][c]   = rawUnder[c];
    end
    hMode[k] = modeSel;
    hTw[k]   = fmtTwos;
    hOe[k]   = oeN;
    hSyn[k]  = syncEnN;
    hRst[k]  = rst_n;
    hDead[k] = pwrDown || !rst_n;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    checkOutputs();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step();
    // Reset state: R11 zero outputs, R9 and R10 drivers off.
    checks++;
    if (dataOut !== '0 || rangeFlag !== '0) begin
      errors++;
      $display("FAIL R11 reset data/flag actual=%h/%b expected=0/0", dataOut, rangeFlag);
    end
    checks++;
    if (dataDrive !== '0 || syncDrive !== 1'b0) begin
      errors++;
      $display("FAIL R9/R10 reset drive actual=%b/%b expected=0/0", dataDrive, syncDrive);
    end
    rst_n = 1'b1;

    for (int md = 0; md < 4; md++) begin
      for (int tw = 0; tw < 2; tw++) begin
        modeSel = md[1:0];
        fmtTwos = tw[0];
        for (int i = 0; i < (1 << CW); i++) begin
          rawCode[0]  = i[CW-1:0];
          rawCode[1]  = CW'((i * 37 + 11) % (1 << CW));
          rawOver[0]  = (i % 13 == 5);
          rawUnder[0] = (i % 17 == 3);
          rawOver[1]  = (i % 11 == 2);
          rawUnder[1] = (i % 11 == 2) || (i % 7 == 1);
          oeN         = NCH'(i[1:0] ^ md[1:0]);
          syncEnN     = i[2];
          pwrDown     = (md == 0) && (tw == 0) && (i >= 4000) && (i < 4003);
          step();
        end
      end
    end
    pwrDown = 1'b0;
    for (int i = 0; i < LAT + 2; i++) step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule